// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits next to a two-port memory and turns the two highest words of that memory into mailboxes, one for each port. The left port owns the word just below the top, and the right port owns the topmost word. When one port writes into the mailbox of the other port, the controller raises an active-low interrupt to the owner of that mailbox. The interrupt stays low until the owner reads its own mailbox.

The controller only watches accesses. It stores no message data, because the message is an ordinary memory word with a meaning the user defines. It does no arbitration either. It receives the busy result of an arbiter that sits elsewhere, and a port that is told it is busy can neither set the other port's interrupt nor clear its own. All decisions are taken on the rising clock edge that samples an access, so an interrupt output changes one cycle after the access that causes the change.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, both `lt_irq_n` and `rt_irq_n` are high.
- R2: An unbusied left write (`lt_sel`=1, `lt_wr`=1, `lt_busy`=0) to the all-ones address drives `rt_irq_n` low on the next cycle.
- R3: An unbusied right write to the address all-ones minus one drives `lt_irq_n` low on the next cycle.
- R4: An unbusied read by a port of its own mailbox (`*_wr`=0; left owns all-ones minus one, right owns all-ones) returns that port's interrupt output high on the next cycle.
- R5: A read by a port of the other port's mailbox leaves both interrupt outputs unchanged.
- R6: When `*_busy` is high for a port, that port's write to the other mailbox leaves the other port's interrupt unchanged.
- R7: When `*_busy` is high for a port, that port's read of its own mailbox leaves its own interrupt unchanged.
- R8: If a set and a clear of the same interrupt fall in the same cycle, the set wins and the output is low on the next cycle.
- R9: A write by a port into its own mailbox, any access to an address below the two mailboxes, and any cycle with `*_sel` low leave both interrupt outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lt_sel | input | 1 | Left port access valid this cycle |
| lt_wr | input | 1 | Left access is a write (1) or a read (0) |
| lt_addr | input | AW | Left word address |
| lt_busy | input | 1 | Left port lost arbitration this cycle |
| rt_sel | input | 1 | Right port access valid this cycle |
| rt_wr | input | 1 | Right access is a write (1) or a read (0) |
| rt_addr | input | AW | Right word address |
| rt_busy | input | 1 | Right port lost arbitration this cycle |
| lt_irq_n | output | 1 | Interrupt to the left port, active low |
| rt_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
Directed sequences cover the cases that the requirements separate. These are a set by the opposite port, a clear by the owner, a read of the foreign mailbox, a write into the port's own mailbox, and each of these repeated with busy held high. A same-cycle set and clear shows whether the set wins over the clear. Random traffic then biases addresses toward the two mailbox words, toggles busy, and sometimes lets both ports hit the same mailbox at once. This mix tests the address decode, the direction decode, and the owner/peer decode against each other, because only the exact combination of port, address, direction and busy may move a flag.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    typedef struct packed {
        logic set_peer;
        logic clr_own;
    } mbx_evt_t;

    function automatic logic flag_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int    AW   = 12,
    parameter side_e SIDE = SIDE_LEFT
) (
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic          busy,
    output mbx_evt_t      evt
);
    localparam logic [AW-1:0] TOP_WORD  = '1;
    localparam logic [AW-1:0] NEXT_WORD = TOP_WORD - 1'b1;
    localparam logic [AW-1:0] OWN_WORD  = (SIDE == SIDE_RIGHT) ? TOP_WORD : NEXT_WORD;
    localparam logic [AW-1:0] PEER_WORD = (SIDE == SIDE_RIGHT) ? NEXT_WORD : TOP_WORD;

    logic granted;

    always_comb begin
        granted      = sel & ~busy;
        evt.set_peer = granted & wr & (addr == PEER_WORD);
        evt.clr_own  = granted & ~wr & (addr == OWN_WORD);
    end
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst) pending <= 1'b0;
        else     pending <= flag_next(pending, set, clr);
    end

    assign irq_n = ~pending;
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lt_sel,
    input  logic          lt_wr,
    input  logic [AW-1:0] lt_addr,
    input  logic          lt_busy,
    input  logic          rt_sel,
    input  logic          rt_wr,
    input  logic [AW-1:0] rt_addr,
    input  logic          rt_busy,
    output logic          lt_irq_n,
    output logic          rt_irq_n
);
    localparam int NPORT = 2;

    logic [NPORT-1:0]   sel_v, wr_v, busy_v, irq_v;
    logic [AW-1:0]      addr_v [NPORT];
    mbx_evt_t           evt_v  [NPORT];

    assign sel_v  = {rt_sel,  lt_sel};
    assign wr_v   = {rt_wr,   lt_wr};
    assign busy_v = {rt_busy, lt_busy};
    assign addr_v[0] = lt_addr;
    assign addr_v[1] = rt_addr;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        mbx_port_decode #(
            .AW   (AW),
            .SIDE ((i == 0) ? SIDE_LEFT : SIDE_RIGHT)
        ) dec_i (
            .sel  (sel_v[i]),
            .wr   (wr_v[i]),
            .addr (addr_v[i]),
            .busy (busy_v[i]),
            .evt  (evt_v[i])
        );

        mbx_irq_flag flag_i (
            .clk   (clk),
            .rst   (rst),
            .set   (evt_v[NPORT-1-i].set_peer),
            .clr   (evt_v[i].clr_own),
            .irq_n (irq_v[i])
        );
    end

    assign lt_irq_n = irq_v[0];
    assign rt_irq_n = irq_v[1];
endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          lt_sel,
    input logic          lt_wr,
    input logic [AW-1:0] lt_addr,
    input logic          lt_busy,
    input logic          rt_sel,
    input logic          rt_wr,
    input logic [AW-1:0] rt_addr,
    input logic          rt_busy,
    input logic          lt_irq_n,
    input logic          rt_irq_n
);
    localparam logic [AW-1:0] TOPW = '1;
    localparam logic [AW-1:0] NXTW = TOPW - 1'b1;

    // R1: reset releases both interrupts
    p_reset_high_r1: assert property (@(posedge clk) rst |=> (lt_irq_n && rt_irq_n));

    // R2: left write to the top word raises the right interrupt
    p_set_right_r2: assert property (@(posedge clk) disable iff (rst)
        (lt_sel && lt_wr && !lt_busy && lt_addr == TOPW) |=> !rt_irq_n);

    // R3: right write to the next word raises the left interrupt
    p_set_left_r3: assert property (@(posedge clk) disable iff (rst)
        (rt_sel && rt_wr && !rt_busy && rt_addr == NXTW) |=> !lt_irq_n);

    // R4: owner read clears when no set competes
    p_clr_right_r4: assert property (@(posedge clk) disable iff (rst)
        (rt_sel && !rt_wr && !rt_busy && rt_addr == TOPW &&
         !(lt_sel && lt_wr && !lt_busy && lt_addr == TOPW)) |=> rt_irq_n);

    // R6: the right interrupt falls only after an unbusied left write to its mailbox
    p_fall_right_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(rt_irq_n) |-> $past(lt_sel && lt_wr && !lt_busy && lt_addr == TOPW));

    p_fall_left_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(lt_irq_n) |-> $past(rt_sel && rt_wr && !rt_busy && rt_addr == NXTW));

    // R7: an interrupt rises only after an unbusied owner read of its mailbox
    p_rise_right_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rt_irq_n) |-> $past(rt_sel && !rt_wr && !rt_busy && rt_addr == TOPW));

    p_rise_left_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(lt_irq_n) |-> $past(lt_sel && !lt_wr && !lt_busy && lt_addr == NXTW));
endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst(rst),
    .lt_sel(lt_sel), .lt_wr(lt_wr), .lt_addr(lt_addr), .lt_busy(lt_busy),
    .rt_sel(rt_sel), .rt_wr(rt_wr), .rt_addr(rt_addr), .rt_busy(rt_busy),
    .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
);

// File: tb/mbx_irq_ctrl_tb_top.sv
module mbx_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam logic [AW-1:0] TOPW = '1;
    localparam logic [AW-1:0] NXTW = TOPW - 1'b1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lt_sel = 0, lt_wr = 0, lt_busy = 0;
    logic rt_sel = 0, rt_wr = 0, rt_busy = 0;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic lt_irq_n, rt_irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit exp_lt = 0, exp_rt = 0; // pending flags, 1 = interrupt asserted

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_irq_ctrl #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst),
        .lt_sel(lt_sel), .lt_wr(lt_wr), .lt_addr(lt_addr), .lt_busy(lt_busy),
        .rt_sel(rt_sel), .rt_wr(rt_wr), .rt_addr(rt_addr), .rt_busy(rt_busy),
        .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
    );

    function automatic bit is_set(bit s, bit w, logic [AW-1:0] a, bit b, logic [AW-1:0] peer);
        return s && w && !b && (a == peer);
    endfunction

    function automatic bit is_clr(bit s, bit w, logic [AW-1:0] a, bit b, logic [AW-1:0] own);
        return s && !w && !b && (a == own);
    endfunction

    function automatic string tag_of(bit st, bit cl, bit blocked_st, bit blocked_cl, bit rd_foreign);
        if (st && cl)    return "R8";
        if (st)          return "R2/R3";
        if (cl)          return "R4";
        if (blocked_st)  return "R6";
        if (blocked_cl)  return "R7";
        if (rd_foreign)  return "R5";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // drive one cycle of traffic (caller is at a negedge), then check at the next negedge
    task automatic apply(input bit ls, input bit lw, input logic [AW-1:0] la, input bit lb,
                         input bit rs, input bit rw, input logic [AW-1:0] ra, input bit rb,
                         input string force_tag);
        bit st_r, cl_r, st_l, cl_l;
        string tl, tr;
        lt_sel = ls; lt_wr = lw; lt_addr = la; lt_busy = lb;
        rt_sel = rs; rt_wr = rw; rt_addr = ra; rt_busy = rb;
        st_r = is_set(ls, lw, la, lb, TOPW);
        cl_r = is_clr(rs, rw, ra, rb, TOPW);
        st_l = is_set(rs, rw, ra, rb, NXTW);
        cl_l = is_clr(ls, lw, la, lb, NXTW);
        tr = tag_of(st_r, cl_r, ls && lw && lb && la == TOPW, rs && !rw && rb && ra == TOPW,
                    ls && !lw && la == TOPW);
        tl = tag_of(st_l, cl_l, rs && rw && rb && ra == NXTW, ls && !lw && lb && la == NXTW,
                    rs && !rw && ra == NXTW);
        if (force_tag != "") begin tr = force_tag; tl = force_tag; end
        exp_rt = st_r | (exp_rt & ~cl_r);
        exp_lt = st_l | (exp_lt & ~cl_l);
        @(negedge clk);
        check(tr, rt_irq_n, ~exp_rt);
        check(tl, lt_irq_n, ~exp_lt);
    endtask

    task automatic idle();
        apply(0, 0, '0, 0, 0, 0, '0, 0, "R9");
    endtask

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        check("R1", lt_irq_n, 1'b1);
        check("R1", rt_irq_n, 1'b1);
        rst = 1'b0;
        idle(); // R1: first cycle after reset still high

        // R2 then R4
        apply(1, 1, TOPW, 0, 0, 0, '0, 0, "R2");
        idle();
        apply(0, 0, '0, 0, 1, 0, TOPW, 0, "R4");
        // R3 then R5 (left reads right's mailbox: no effect) then R4
        apply(0, 0, '0, 0, 1, 1, NXTW, 0, "R3");
        apply(1, 0, TOPW, 0, 0, 0, '0, 0, "R5");
        apply(0, 0, '0, 0, 1, 0, NXTW, 0, "R5");
        apply(1, 0, NXTW, 0, 0, 0, '0, 0, "R4");
        // R6: busy blocks the set
        apply(1, 1, TOPW, 1, 1, 1, NXTW, 1, "R6");
        // R7: busy blocks the clear
        apply(1, 1, TOPW, 0, 1, 1, NXTW, 0, "R2");
        apply(1, 0, NXTW, 1, 1, 0, TOPW, 1, "R7");
        apply(0, 0, '0, 0, 0, 0, '0, 0, "R7");
        // R8: same-cycle set and clear of the right flag; set wins
        apply(1, 1, TOPW, 0, 1, 0, TOPW, 0, "R8");
        apply(0, 0, '0, 0, 1, 0, TOPW, 0, "R4");
        apply(1, 0, NXTW, 0, 0, 0, '0, 0, "R4");
        // R9: own-mailbox writes, low addresses, deselected cycles
        apply(1, 1, NXTW, 0, 1, 1, TOPW, 0, "R9");
        apply(1, 1, NXTW - 1'b1, 0, 1, 1, '0, 0, "R9");
        apply(0, 1, TOPW, 0, 0, 1, NXTW, 0, "R9");

        // random traffic biased toward the mailbox words
        for (int k = 0; k < 600; k++) begin
            logic [AW-1:0] la, ra;
            int pl = $urandom_range(0, 3);
            int pr = $urandom_range(0, 3);
            la = (pl == 0) ? TOPW : (pl == 1) ? NXTW : (pl == 2) ? NXTW - 1'b1 : AW'($urandom);
            ra = (pr == 0) ? TOPW : (pr == 1) ? NXTW : (pr == 2) ? NXTW - 1'b1 : AW'($urandom);
            apply($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, la, $urandom_range(0, 3) == 0,
                  $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, ra, $urandom_range(0, 3) == 0, "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule